// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time in packed BCD registers: seconds, minutes, hours, day of month, month, two-digit year and century. It also keeps a 3-bit binary weekday. A free-running base strobe feeds an internal prescaler. Every `PRESCALE` strobes the prescaler advances the time by one second. The carries run through a full calendar: month lengths, February in leap years, the year wrapping into the century, and the weekday wrapping at midnight.

Software reaches the block through a flat byte-wide register port. The write side is synchronous. The read side is combinational on a separate read address.

**Loading the time.** Writes to the time registers go into a staging copy first. Writing the last time register, the century, copies the whole staging set into the running counters in one step. The same commit clears the sub-second prescaler and clears the power-fail flag.

**Alarm.** One alarm register set mirrors the time layout. Bit 7 of its seconds, minutes, hours, date and month bytes enables comparison of that field. When the time steps to a value where every enabled field matches, a sticky flag is set in status. An interrupt line reports that flag while the alarm interrupt enable is set.

Top module: `bcd_rtc_alarm`

## Requirements
- R1: After reset, reads return the following.
  - Time registers at 0x30 to 0x37 (seconds, minutes, hours, date, month, year, weekday, century): 0x00, 0x00, 0x80, 0x01, 0x01, 0x00, 0x00, 0x20.
  - Status at 0x3F: 0x01 (bit 0 = power-fail flag).
  - Interrupt enable register at 0x11: 0x00.
  - Alarm registers at 0x00 to 0x07: 0x00.
  - `irq`: low.
- R2: The seconds register advances by one BCD count after exactly `PRESCALE` cycles with `base_tick` high, counted from the last commit. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into the date.
- R3: The date wraps to 01 and carries into the month after day 30 in April, June, September and November, and after day 31 in the other months except February.
- R4: In February the date wraps after day 29 when the BCD year is divisible by 4, and after day 28 otherwise.
- R5: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the BCD century, so century 0x19 becomes 0x20.
- R6: The weekday (bits 2:0 of 0x36) increments only when the hours wrap at midnight. It wraps from 6 to 0.
- R7: Writes to 0x30 to 0x36 leave the running time unchanged. A write to 0x37 loads all eight staged values at once, clears the prescaler and clears status bit 0.
- R8: Bit 7 of the hours register is stored and read back as written. Counting is 24-hour whatever its value. The hour count sits in bits 5:0.
- R9: When the time steps to a new second, status bit 5 is set if two conditions hold.
  - At least one alarm field has its enable (bit 7) set.
  - Every enabled field equals the new time. Compared bits are 6:0 for seconds, minutes, date and month, and 5:0 for hours.
  
  Fields with the enable clear are ignored.
- R10: `irq` is high exactly while status bit 5 and interrupt register bit 5 are both set. Status bit 5 stays set until software writes 0x3F with bit 5 clear.
- R11: A commit that loads a time matching the alarm does not set status bit 5. Only a one-second step can set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | Prescaler strobe; `PRESCALE` strobes make one second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The bench builds the block with `PRESCALE` set to 4, so each simulated second costs four clock cycles. At that rate the bench can step through whole calendar boundaries one second at a time: month ends, leap and common Februaries, and the year and century wrap. It can also count the prescaler cycle by cycle right after a commit. Alarm scenarios cover the following cases:
- a match on enabled fields with a mismatching field disabled;
- a mismatch on an enabled field;
- no fields enabled;
- a commit that lands directly on the alarm time.

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm #(
  parameter int PRESCALE = 32768,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(6'h30);
  localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(6'h37);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6'h3F);
  localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(6'h11);

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    return y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
  endfunction

  logic [PW-1:0] presc;
  logic [7:0] sec, mnt, hr, date, mon, yr, cen;
  logic [2:0] wd;
  logic [7:0] st_sec, st_mnt, st_hr, st_date, st_mon, st_yr;
  logic [2:0] st_wd;
  logic [7:0] alm [8];
  logic       int_en, alm_flag, fail;

  wire commit   = wr_en && (wr_addr == A_CEN);
  wire sec_step = base_tick && (presc == PMAX) && !commit;

  logic [7:0] last_day;
  always_comb begin
    case (mon)
      8'h02:                      last_day = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  wire w_sec = (sec == 8'h59);
  wire w_min = w_sec && (mnt == 8'h59);
  wire w_day = w_min && (hr[5:0] == 6'h23);
  wire w_mon = w_day && (date == last_day);
  wire w_yr  = w_mon && (mon == 8'h12);
  wire w_cen = w_yr && (yr == 8'h99);

  wire [7:0] n_sec  = w_sec ? 8'h00 : inc_bcd(sec);
  wire [7:0] n_mnt  = w_sec ? ((mnt == 8'h59) ? 8'h00 : inc_bcd(mnt)) : mnt;
  wire [7:0] n_hr   = w_min ? ((hr[5:0] == 6'h23) ? {hr[7], 7'h00} : {hr[7], 1'b0, inc_bcd({2'b00, hr[5:0]})[5:0]}) : hr;
  wire [7:0] n_date = w_day ? ((date == last_day) ? 8'h01 : inc_bcd(date)) : date;
  wire [7:0] n_mon  = w_mon ? ((mon == 8'h12) ? 8'h01 : inc_bcd(mon)) : mon;
  wire [7:0] n_yr   = w_yr  ? ((yr == 8'h99) ? 8'h00 : inc_bcd(yr)) : yr;
  wire [7:0] n_cen  = w_cen ? inc_bcd(cen) : cen;
  wire [2:0] n_wd   = w_day ? ((wd >= 3'd6) ? 3'd0 : wd + 3'd1) : wd;

  logic match;
  always_comb begin
    logic any_en;
    logic [7:0] nf [5];
    nf[0] = n_sec; nf[1] = n_mnt; nf[2] = {2'b00, n_hr[5:0]}; nf[3] = n_date; nf[4] = n_mon;
    any_en = 1'b0;
    match  = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (alm[i][7]) begin
        any_en = 1'b1;
        if (i == 2) begin
          if (alm[i][5:0] != nf[i][5:0]) match = 1'b0;
        end else begin
          if (alm[i][6:0] != nf[i][6:0]) match = 1'b0;
        end
      end
    end
    match = match && any_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      sec <= 8'h00; mnt <= 8'h00; hr <= 8'h80; date <= 8'h01;
      mon <= 8'h01; yr <= 8'h00; wd <= 3'd0; cen <= 8'h20;
    end else if (commit) begin
      presc <= '0;
      sec <= st_sec; mnt <= st_mnt; hr <= st_hr; date <= st_date;
      mon <= st_mon; yr <= st_yr; wd <= st_wd; cen <= wr_data;
    end else if (base_tick) begin
      presc <= (presc == PMAX) ? '0 : presc + 1'b1;
      if (sec_step) begin
        sec <= n_sec; mnt <= n_mnt; hr <= n_hr; date <= n_date;
        mon <= n_mon; yr <= n_yr; wd <= n_wd; cen <= n_cen;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sec <= 8'h00; st_mnt <= 8'h00; st_hr <= 8'h80; st_date <= 8'h01;
      st_mon <= 8'h01; st_yr <= 8'h00; st_wd <= 3'd0;
    end else if (wr_en) begin
      case (wr_addr)
        A_TIME:                   st_sec  <= wr_data;
        A_TIME + ADDR_W'(1):      st_mnt  <= wr_data;
        A_TIME + ADDR_W'(2):      st_hr   <= {wr_data[7], 1'b0, wr_data[5:0]};
        A_TIME + ADDR_W'(3):      st_date <= wr_data;
        A_TIME + ADDR_W'(4):      st_mon  <= wr_data;
        A_TIME + ADDR_W'(5):      st_yr   <= wr_data;
        A_TIME + ADDR_W'(6):      st_wd   <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) alm[i] <= 8'h00;
      int_en <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr < ADDR_W'(8)) alm[wr_addr[2:0]] <= wr_data;
      if (wr_addr == A_INT) int_en <= wr_data[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_flag <= 1'b0;
      fail     <= 1'b1;
    end else begin
      if (sec_step && match)                                alm_flag <= 1'b1;
      else if (wr_en && wr_addr == A_STAT && !wr_data[5])   alm_flag <= 1'b0;
      if (commit) fail <= 1'b0;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < ADDR_W'(8)) rd_data = alm[rd_addr[2:0]];
    else begin
      case (rd_addr)
        A_TIME:              rd_data = sec;
        A_TIME + ADDR_W'(1): rd_data = mnt;
        A_TIME + ADDR_W'(2): rd_data = hr;
        A_TIME + ADDR_W'(3): rd_data = date;
        A_TIME + ADDR_W'(4): rd_data = mon;
        A_TIME + ADDR_W'(5): rd_data = yr;
        A_TIME + ADDR_W'(6): rd_data = {5'b0, wd};
        A_CEN:               rd_data = cen;
        A_STAT:              rd_data = {2'b00, alm_flag, 4'b0000, fail};
        A_INT:               rd_data = {2'b00, int_en, 5'b00000};
        default:             rd_data = 8'h00;
      endcase
    end
  end

  assign irq = alm_flag & int_en;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && sec == 8'h59) |=> (sec == 8'h00)); // R2
  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && sec == 8'h59 && mnt == 8'h59 && hr[5:0] == 6'h23 && wd == 3'd6) |=> (wd == 3'd0)); // R6
  AST_CENTURY_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && sec == 8'h59 && mnt == 8'h59 && hr[5:0] == 6'h23 && date == 8'h31 &&
     mon == 8'h12 && yr == 8'h99 && cen == 8'h19) |=> (yr == 8'h00 && cen == 8'h20 && mon == 8'h01)); // R5
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!fail && !sec_step)); // R7
  AST_FLAG_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past(sec_step)); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq); // R10
endmodule

// File: tb/bcd_rtc_alarm_test.sv
module bcd_rtc_alarm_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0, base_tick = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;

  bcd_rtc_alarm #(.PRESCALE(P), .ADDR_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, pending = 0;
  bit finished = 0;
  logic [7:0] addr_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  initial begin
    forever begin
      logic [7:0] a, e, act;
      string t;
      wait (addr_q.size() > 0);
      a = addr_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      if (a != 8'hFF) rd_addr = a[5:0];
      #1;
      act = (a == 8'hFF) ? {7'b0, irq} : rd_data;
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", t, a, act, e);
      end
      pending--;
    end
  end

  task automatic expect_val(input logic [7:0] a, input logic [7:0] e, input string t);
    pending++;
    addr_q.push_back(a); exp_q.push_back(e); tag_q.push_back(t);
    wait (pending == 0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, m, h, dt, mo, y, w, c);
    wr(6'h30, s); wr(6'h31, m); wr(6'h32, h); wr(6'h33, dt);
    wr(6'h34, mo); wr(6'h35, y); wr(6'h36, w); wr(6'h37, c);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); base_tick = 1'b1;
    repeat (n) @(negedge clk);
    base_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_val(8'h30, 8'h00, "R1 sec"); expect_val(8'h31, 8'h00, "R1 min");
    expect_val(8'h32, 8'h80, "R1 hour"); expect_val(8'h33, 8'h01, "R1 date");
    expect_val(8'h34, 8'h01, "R1 month"); expect_val(8'h35, 8'h00, "R1 year");
    expect_val(8'h36, 8'h00, "R1 wday"); expect_val(8'h37, 8'h20, "R1 century");
    expect_val(8'h3F, 8'h01, "R1 status"); expect_val(8'h11, 8'h00, "R1 int");
    expect_val(8'h00, 8'h00, "R1 alarm"); expect_val(8'hFF, 8'h00, "R1 irq");

    // R7 staging does not reach the live time
    wr(6'h30, 8'h45);
    expect_val(8'h30, 8'h00, "R7 staged sec hidden");

    // R7 R8 commit, 30 April 23:59:58 with hours bit 7 clear
    load(8'h58, 8'h59, 8'h23, 8'h30, 8'h04, 8'h23, 8'h06, 8'h20);
    expect_val(8'h30, 8'h58, "R7 committed sec");
    expect_val(8'h32, 8'h23, "R8 hour mode bit kept clear");
    expect_val(8'h3F, 8'h00, "R7 fail flag cleared");
    ticks(P - 1);
    expect_val(8'h30, 8'h58, "R2 no step before prescale");
    ticks(1);
    expect_val(8'h30, 8'h59, "R2 step at prescale");
    ticks(P);
    expect_val(8'h30, 8'h00, "R2 sec wrap"); expect_val(8'h31, 8'h00, "R2 min wrap");
    expect_val(8'h32, 8'h00, "R2 R8 hour wrap 24h");
    expect_val(8'h33, 8'h01, "R3 30-day month end"); expect_val(8'h34, 8'h05, "R3 month carry");
    expect_val(8'h36, 8'h00, "R6 weekday wrap");

    // R4 leap February
    load(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h02, 8'h20);
    ticks(P);
    expect_val(8'h33, 8'h29, "R4 leap day"); expect_val(8'h34, 8'h02, "R4 leap month");
    expect_val(8'h32, 8'h80, "R8 hour bit7 kept"); expect_val(8'h36, 8'h03, "R6 weekday inc");
    ticks(P);
    expect_val(8'h36, 8'h03, "R6 no inc off midnight");
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h00, 8'h20);
    ticks(P);
    expect_val(8'h33, 8'h01, "R4 common Feb end"); expect_val(8'h34, 8'h03, "R4 common month");

    // R3 31-day month
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h23, 8'h00, 8'h20);
    ticks(P);
    expect_val(8'h33, 8'h01, "R3 31-day end"); expect_val(8'h34, 8'h02, "R3 month 2");

    // R5 year and century
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h04, 8'h19);
    ticks(P);
    expect_val(8'h34, 8'h01, "R5 month wrap"); expect_val(8'h35, 8'h00, "R5 year wrap");
    expect_val(8'h37, 8'h20, "R5 century inc");

    // R9 R10 alarm on seconds and minutes, hours disabled
    wr(6'h00, 8'h85); wr(6'h01, 8'h80);
    load(8'h03, 8'h00, 8'h10, 8'h01, 8'h01, 8'h24, 8'h01, 8'h20);
    ticks(P);
    expect_val(8'h3F, 8'h00, "R9 no match yet");
    ticks(P);
    expect_val(8'h3F, 8'h20, "R9 match sets flag");
    expect_val(8'hFF, 8'h00, "R10 irq gated off");
    wr(6'h11, 8'h20);
    expect_val(8'h11, 8'h20, "R10 int enable readback");
    expect_val(8'hFF, 8'h01, "R10 irq asserted");
    ticks(P);
    expect_val(8'h3F, 8'h20, "R10 flag sticky");
    wr(6'h3F, 8'h00);
    expect_val(8'h3F, 8'h00, "R10 flag cleared");
    expect_val(8'hFF, 8'h00, "R10 irq cleared");

    // R11 commit onto alarm time
    load(8'h05, 8'h00, 8'h10, 8'h01, 8'h01, 8'h24, 8'h01, 8'h20);
    expect_val(8'h3F, 8'h00, "R11 commit no flag");

    // R9 enabled field mismatch
    wr(6'h01, 8'h81);
    load(8'h04, 8'h00, 8'h10, 8'h01, 8'h01, 8'h24, 8'h01, 8'h20);
    ticks(P);
    expect_val(8'h3F, 8'h00, "R9 enabled mismatch");
    expect_val(8'hFF, 8'h00, "R9 irq stays low");

    // R9 no field enabled
    wr(6'h00, 8'h05); wr(6'h01, 8'h00);
    load(8'h04, 8'h00, 8'h10, 8'h01, 8'h01, 8'h24, 8'h01, 8'h20);
    ticks(P);
    expect_val(8'h30, 8'h05, "R9 time reached");
    expect_val(8'h3F, 8'h00, "R9 no enables no match");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule